// File: doc/BRIEF.md
# Control-Flow-Bound Instruction Decryptor

This block sits between instruction memory and the fetch stage of a processor. Each instruction word held in memory is stored masked with a 32-bit pad. The pad is a keyed mix of two program counters: the address of the instruction that was last handed to the processor, and the address now being fetched. The block recomputes that pad and removes it. When execution follows the intended path, the pad matches and the original instruction comes out. If a fault makes the processor skip an instruction or jump somewhere unexpected, the address pair is wrong. The pad then differs and the processor receives an unusable word instead of a valid instruction.

A fetch is offered with a valid/ready handshake: an address, the stored word and a valid strobe. Once a fetch is accepted, the block lowers its ready output and runs the mixing rounds, one per clock. After the last round it presents the recovered instruction with its own valid/ready handshake. The remembered predecessor address is replaced only when the consumer takes an instruction. Programs must be laid out so that each instruction has exactly one predecessor. Join points need a separate mechanism outside this block.

Top module: `flow_bound_decryptor`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. The remembered predecessor address is `ENTRY_PC`, so the first fetch decodes against the pair (`ENTRY_PC`, fetch address).
- R2: In the cycle after a fetch is accepted (`in_valid` and `in_ready` both high at a clock edge), `in_ready` is 0. It stays 0 until the recovered instruction has been taken.
- R3: `out_valid` rises exactly `ROUNDS` clock edges after the edge that accepts a fetch, and not before.
- R4: `out_insn` equals the stored word XOR the pad. The pad is computed from seed a = prev XOR key and b = cur + key. Each round i (0 to `ROUNDS`-1) then sets a = (a + rotl(b,5)) XOR (key + i·0x9E3779B9) and b = (b XOR rotl(a,13)) + key, using the new value of a. The pad is a XOR b after the last round.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_insn` does not change.
- R6: The predecessor address changes only on an output handshake, and it becomes the address of the instruction just taken. A fetch that follows any delivered address decodes correctly against that address.
- R7: A fetch whose true predecessor was skipped yields a word that differs from the original instruction.
- R8: Values on `in_valid`, `in_addr` and `in_word` while `in_ready` is 0 have no effect on the instruction delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key | input | 32 | Secret mixing key, held stable during operation |
| in_valid | input | 1 | Fetch offered |
| in_ready | output | 1 | Block can accept a fetch |
| in_addr | input | ADDR_W | Fetch address |
| in_word | input | INSN_W | Stored (masked) instruction word |
| out_valid | output | 1 | Recovered instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | INSN_W | Recovered instruction |

## Verification
The bench builds the block with its default values: 32-bit addresses and words, four mixing rounds, and an entry address of 0xFC in front of a program placed at 0x100. With four rounds, the bench can compare every busy cycle, the exact edge at which the output appears, and long consumer stalls against its reference model within a short run. With the entry value next to the program start, both the first-fetch case and a deliberately skipped address can be exercised on the same small straight-line program.

// File: rtl/flow_dec_pkg.sv
package flow_dec_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
    } mix_t;

    localparam logic [31:0] ROUND_STEP = 32'h9E37_79B9;

    function automatic logic [31:0] rotl32(input logic [31:0] x, input int unsigned s);
        return (x << s) | (x >> (32 - s));
    endfunction

endpackage

// File: rtl/mix_round.sv
module mix_round
    import flow_dec_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  mix_t              st_i,
    input  logic [31:0]       key_i,
    input  logic [IDX_W-1:0]  round_i,
    output mix_t              st_o
);

    logic [31:0] round_const;
    logic [31:0] a_new;

    always_comb begin
        round_const = key_i + ROUND_STEP * 32'(round_i);
        a_new       = (st_i.a + rotl32(st_i.b, 5)) ^ round_const;
        st_o.a      = a_new;
        st_o.b      = (st_i.b ^ rotl32(a_new, 13)) + key_i;
    end

endmodule

// File: rtl/pad_engine.sv
module pad_engine
    import flow_dec_pkg::*;
#(
    parameter int ROUNDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] key_i,
    input  logic [31:0] prev_pc_i,
    input  logic [31:0] cur_pc_i,
    output logic        done_o,
    output logic [31:0] pad_o
);

    localparam int CNT_W = $clog2(ROUNDS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        mix_t             st;
    } eng_t;

    eng_t q, d;
    mix_t rnd_out;

    mix_round #(.IDX_W(CNT_W)) u_round (
        .st_i    (q.st),
        .key_i   (key_i),
        .round_i (q.cnt),
        .st_o    (rnd_out)
    );

    always_comb begin
        d = q;
        if (start_i) begin
            d.st.a = prev_pc_i ^ key_i;
            d.st.b = cur_pc_i + key_i;
            d.cnt  = '0;
            d.busy = 1'b1;
            d.done = 1'b0;
        end else if (q.busy) begin
            d.st  = rnd_out;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign pad_o  = q.st.a ^ q.st.b;

    // R3: a fresh run never reports completion on the next cycle
    a_r3_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

    // R3: completion only follows a running computation
    a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(q.busy));

endmodule

// File: rtl/pc_history.sv
module pc_history #(
    parameter logic [31:0] ENTRY = 32'h0000_00FC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_i,
    input  logic [31:0] new_pc_i,
    output logic [31:0] prev_o
);

    logic [31:0] prev_q, prev_d;

    always_comb begin
        prev_d = prev_q;
        if (upd_i) prev_d = new_pc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= ENTRY;
        else        prev_q <= prev_d;
    end

    assign prev_o = prev_q;

    // R6: without a handoff the predecessor stays put
    a_r6_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(prev_o));

    // R6: a handoff records the delivered address
    a_r6_prev_load: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> prev_o == $past(new_pc_i));

endmodule

// File: rtl/flow_bound_decryptor.sv
module flow_bound_decryptor
    import flow_dec_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          INSN_W   = 32,
    parameter int          ROUNDS   = 4,
    parameter logic [31:0] ENTRY_PC = 32'h0000_00FC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       key,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [INSN_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [INSN_W-1:0] out_insn
);

    localparam int PC_W = 32;

    typedef struct packed {
        phase_e             phase;
        logic [PC_W-1:0]    pc;
        logic [INSN_W-1:0]  word;
    } top_t;

    top_t q, d;

    logic [PC_W-1:0] fetch_pc;
    logic [31:0]     prev_pc;
    logic [31:0]     pad;
    logic            eng_done;
    logic            accept;
    logic            handoff;

    generate
        if (ADDR_W < PC_W) begin : g_ext
            assign fetch_pc = {{(PC_W-ADDR_W){1'b0}}, in_addr};
        end else begin : g_full
            assign fetch_pc = in_addr[PC_W-1:0];
        end
    endgenerate

    assign in_ready  = (q.phase == PH_IDLE);
    assign out_valid = (q.phase == PH_WAIT) && eng_done;
    assign out_insn  = q.word ^ pad[INSN_W-1:0];
    assign accept    = in_valid && in_ready;
    assign handoff   = out_valid && out_ready;

    always_comb begin
        d = q;
        if (accept) begin
            d.phase = PH_WAIT;
            d.pc    = fetch_pc;
            d.word  = in_word;
        end else if (handoff) begin
            d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    pad_engine #(.ROUNDS(ROUNDS)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .key_i     (key),
        .prev_pc_i (prev_pc),
        .cur_pc_i  (fetch_pc),
        .done_o    (eng_done),
        .pad_o     (pad)
    );

    pc_history #(.ENTRY(ENTRY_PC)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (handoff),
        .new_pc_i (q.pc),
        .prev_o   (prev_pc)
    );

    // R2: an accepted fetch closes the input on the next cycle
    a_r2_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R3: no output in the cycle right after acceptance
    a_r3_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !out_valid);

    // R5: a stalled output holds its value
    a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_insn)));

    // R8: while closed, input activity changes neither readiness nor the captured word
    a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !handoff) |=> (!in_ready && $stable(q.word) && $stable(q.pc)));

endmodule

// File: tb/flow_bound_decryptor_tb.sv
module flow_bound_decryptor_tb;

    localparam int          ROUNDS = 4;
    localparam logic [31:0] ENTRY  = 32'h0000_00FC;
    localparam logic [31:0] BASE   = 32'h0000_0100;
    localparam logic [31:0] KEY    = 32'h5A17_C3E9;
    localparam int          NPROG  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_insn;

    always #2 clk = ~clk;

    flow_bound_decryptor #(
        .ADDR_W(32), .INSN_W(32), .ROUNDS(ROUNDS), .ENTRY_PC(ENTRY)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .key(KEY),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int          m_phase = 0;
    int          m_cnt   = 0;
    logic [31:0] m_prev  = ENTRY;
    logic [31:0] m_addr  = '0;
    logic [31:0] m_exp   = '0;
    logic [31:0] last_out = '0;

    function automatic logic [31:0] ref_pad(input logic [31:0] p, input logic [31:0] c);
        logic [31:0] x, y;
        x = p ^ KEY;
        y = c + KEY;
        for (int i = 0; i < ROUNDS; i++) begin
            x = (x + ((y << 5) | (y >> 27))) ^ (KEY + 32'(i) * 32'h9E37_79B9);
            y = (y ^ ((x << 13) | (x >> 19))) + KEY;
        end
        return x ^ y;
    endfunction

    function automatic logic [31:0] plain(input int i);
        return 32'h1300_0013 + 32'(i) * 32'h0101_0203;
    endfunction

    function automatic logic [31:0] addr_of(input int i);
        return BASE + 32'(4 * i);
    endfunction

    function automatic logic [31:0] stored(input int i);
        return plain(i) ^ ref_pad(addr_of(i) - 32'd4, addr_of(i));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: compare outputs with the model, drive new inputs, advance the model
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] w, input logic r);
        @(negedge clk);
        chk(in_ready === (m_phase == 0), "R2", 32'(in_ready), 32'(m_phase == 0));
        chk(out_valid === (m_phase == 2), "R3", 32'(out_valid), 32'(m_phase == 2));
        if (m_phase == 2) begin
            chk(out_insn === m_exp, "R4", out_insn, m_exp);
            if (r) last_out = out_insn;
        end
        in_valid  = v;
        in_addr   = a;
        in_word   = w;
        out_ready = r;
        case (m_phase)
            0: if (v) begin
                m_addr  = a;
                m_exp   = w ^ ref_pad(m_prev, a);
                m_cnt   = 0;
                m_phase = 1;
            end
            1: begin
                m_cnt++;
                if (m_cnt == ROUNDS) m_phase = 2;
            end
            default: if (r) begin
                m_prev  = m_addr;
                m_phase = 0;
            end
        endcase
    endtask

    task automatic fetch(input logic [31:0] a, input logic [31:0] w, input bit junk);
        step(1'b1, a, w, 1'b1);
        for (int k = 0; k < 20 && m_phase != 0; k++)
            step(junk, a ^ 32'h40, ~w, 1'b1);
        step(1'b0, '0, '0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_phase = 0;
        m_cnt = 0;
        m_prev = ENTRY;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        do_reset();
        #1;
        // R1: reset state
        chk(in_ready === 1'b1, "R1", 32'(in_ready), 32'd1);
        chk(out_valid === 1'b0, "R1", 32'(out_valid), 32'd0);

        // R4 / R1: straight-line program recovered exactly, first against ENTRY
        for (int i = 0; i < 8; i++) begin
            fetch(addr_of(i), stored(i), 1'b0);
            chk(last_out === plain(i), i == 0 ? "R1" : "R4", last_out, plain(i));
        end

        // R5 / R6: consumer stall holds output and leaves predecessor untouched
        step(1'b1, addr_of(8), stored(8), 1'b0);
        for (int k = 0; k < 20 && m_phase != 2; k++) step(1'b0, '0, '0, 1'b0);
        @(negedge clk);
        held = out_insn;
        for (int k = 0; k < 6; k++) begin
            step(1'b0, '0, '0, 1'b0);
            chk(out_valid === 1'b1 && out_insn === held, "R5", out_insn, held);
        end
        for (int k = 0; k < 20 && m_phase != 0; k++) step(1'b0, '0, '0, 1'b1);
        chk(last_out === plain(8), "R5", last_out, plain(8));

        // R8: junk offered while busy is ignored
        fetch(addr_of(9), stored(9), 1'b1);
        chk(last_out === plain(9), "R8", last_out, plain(9));

        // R7: skipped instruction yields garbage; R6: successor decodes against delivered address
        do_reset();
        fetch(addr_of(0), stored(0), 1'b0);
        chk(last_out === plain(0), "R4", last_out, plain(0));
        fetch(addr_of(1), stored(1), 1'b0);
        chk(last_out === plain(1), "R4", last_out, plain(1));
        fetch(addr_of(3), stored(3), 1'b0);
        chk(last_out !== plain(3), "R7", last_out, plain(3));
        fetch(addr_of(4), stored(4), 1'b0);
        chk(last_out === plain(4), "R6", last_out, plain(4));

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule